// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit executes the 32-bit instruction that sets the vector length. In the cycle of an execute strobe it decodes the instruction word. It then chooses a new maximum vector length (MVL) and a new current vector length (VL) from one of three sources: a source-register value, a 7-bit immediate plus one, or the value already held. VL is clamped so that it never exceeds MVL. The unit reports VL, zero-extended, as the result for the destination register. On the same clock edge it writes both lengths into a 14-bit vector state register and copies the vertical-first flag into a mode bit.

One flag combination does not touch the lengths: vertical-first set with both selection flags clear. For that combination the unit raises a one-cycle request to advance element stepping. It writes nothing else. All per-instruction outputs are combinational from the instruction word, the source value and the present state. The state register and the mode bit change only at the clock edge.

Top module: `vls_unit`

## Requirements
- R1: An instruction is accepted only when `exec_i` is high, the primary opcode field (word bits 31:26) equals parameter `OPCODE` (default 22) and the extended opcode field (bits 5:1) is zero. Any other word, or `exec_i` low, leaves the state, the mode bit and every strobe output unchanged or idle.
- R2: An accepted word with vf=1 (bit 8), vs=0 (bit 7) and ms=0 (bit 6) raises `step_next_o`. It raises neither `rt_we_o` nor `cr_we_o`, and it leaves VL, MVL and the mode bit unchanged.
- R3: The immediate length is the 7-bit SVi field (bits 15:9) plus one, taken modulo 128, so SVi=127 gives 0.
- R4: With vs=1 and a nonzero RA field (bits 20:16), the new VL is bits 6:0 of `ra_val_i`.
- R5: With vs=1 and RA field zero, the new VL is the immediate length, and `ra_val_i` is ignored.
- R6: With vs=0, the new VL is the VL already held.
- R7: With ms=1, the new MVL is the immediate length. With ms=0, the held MVL is kept.
- R8: If the selected VL exceeds the selected MVL, VL is replaced by MVL. The held VL never exceeds the held MVL.
- R9: An accepted non-step word asserts `rt_we_o`, drives `rt_idx_o` with the RT field (bits 25:21) and drives `rt_data_o` with the new VL zero-extended to 64 bits. At the next edge `mvl_o`/`vl_o` take the new values.
- R10: An accepted non-step word writes vf into the mode bit `vert_mode_o` at the clock edge.
- R11: With Rc=1 (bit 0) on an accepted non-step word, `cr_we_o` is high and `zero_o` is high exactly when the new VL is zero. Otherwise both are low.
- R12: Asynchronous active-low reset clears MVL, VL and the mode bit to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe for the presented word |
| insn_i | input | 32 | Instruction word |
| ra_val_i | input | 64 | Value of the source register named by RA |
| rt_we_o | output | 1 | Destination register write enable |
| rt_idx_o | output | 5 | Destination register index |
| rt_data_o | output | 64 | Destination result, VL zero-extended |
| cr_we_o | output | 1 | Zero flag valid (Rc set) |
| zero_o | output | 1 | New VL is zero |
| step_next_o | output | 1 | Request to advance element stepping |
| mvl_o | output | 7 | Held maximum vector length |
| vl_o | output | 7 | Held current vector length |
| vert_mode_o | output | 1 | Held vertical-first mode bit |

## Verification
The bench gives a source value with its upper bits set, so a design that failed to cut it to seven bits, or failed to zero-extend the result, returns a wrong destination value. It sets SVi to 127, where a design that kept the carry would give 128 and not 0. It gives register VLs above MVL, and shrinks MVL below a retained VL, so a missing clamp leaves VL above MVL. It sends the step-next combination with Rc set and with the mode bit at both values, so a design that wrote the state, the destination or the mode bit there is caught. Wrong opcodes and a nonzero extended opcode under the strobe show any design that decodes too loosely.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
package vls_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned VL_W    = 7;
  localparam int unsigned STATE_W = 2 * VL_W;

  // MSB-first field order equals the word layout, so a cast decodes it
  typedef struct packed {
    logic [5:0]      opc;
    logic [4:0]      rt;
    logic [4:0]      ra;
    logic [VL_W-1:0] svi;
    logic            vf;
    logic            vs;
    logic            ms;
    logic [4:0]      xo;
    logic            rc;
  } vls_insn_t;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_STEP = 2'd1,
    ACT_SET  = 2'd2
  } vls_act_e;
endpackage

// File: rtl/vls_decode.sv
`timescale 1ns/1ps
module vls_decode
  import vls_pkg::*;
#(
  parameter logic [5:0] OPCODE = 6'd22
) (
  input  logic              exec_i,
  input  logic [INSN_W-1:0] insn_i,
  output vls_act_e          act_o,
  output logic [4:0]        rt_o,
  output logic              ra_nz_o,
  output logic [VL_W-1:0]   svi_o,
  output logic              vf_o,
  output logic              vs_o,
  output logic              ms_o,
  output logic              rc_o
);
  vls_insn_t f;
  logic      hit;

  assign f       = vls_insn_t'(insn_i);
  assign hit     = exec_i && (f.opc == OPCODE) && (f.xo == 5'd0);
  assign rt_o    = f.rt;
  assign ra_nz_o = |f.ra;
  assign svi_o   = f.svi;
  assign vf_o    = f.vf;
  assign vs_o    = f.vs;
  assign ms_o    = f.ms;
  assign rc_o    = f.rc;

  always_comb begin
    act_o = ACT_NONE;
    if (hit) begin
      if (f.vf && !f.vs && !f.ms) act_o = ACT_STEP;
      else                        act_o = ACT_SET;
    end
  end
endmodule

// File: rtl/vls_len_select.sv
`timescale 1ns/1ps
module vls_len_select #(
  parameter int unsigned VL_W = 7
) (
  input  logic [VL_W-1:0] svi_i,
  input  logic            ra_nz_i,
  input  logic [VL_W-1:0] ra_low_i,
  input  logic            vs_i,
  input  logic            ms_i,
  input  logic [VL_W-1:0] cur_mvl_i,
  input  logic [VL_W-1:0] cur_vl_i,
  output logic [VL_W-1:0] new_mvl_o,
  output logic [VL_W-1:0] new_vl_o
);
  localparam logic [VL_W-1:0] ONE = {{(VL_W-1){1'b0}}, 1'b1};

  logic [VL_W-1:0] imm_len;
  logic [VL_W-1:0] vl_pick;

  // carry out of the increment is dropped: 127 + 1 wraps to 0
  assign imm_len = svi_i + ONE;

  always_comb begin
    if (!vs_i)        vl_pick = cur_vl_i;
    else if (ra_nz_i) vl_pick = ra_low_i;
    else              vl_pick = imm_len;
  end

  assign new_mvl_o = ms_i ? imm_len : cur_mvl_i;
  assign new_vl_o  = (vl_pick > new_mvl_o) ? new_mvl_o : vl_pick;
endmodule

// File: rtl/vls_state.sv
`timescale 1ns/1ps
module vls_state #(
  parameter int unsigned VL_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [VL_W-1:0] new_mvl_i,
  input  logic [VL_W-1:0] new_vl_i,
  input  logic            vf_i,
  output logic [VL_W-1:0] mvl_o,
  output logic [VL_W-1:0] vl_o,
  output logic            mode_o
);
  localparam int unsigned STATE_W = 2 * VL_W;

  // upper half MVL, lower half VL
  logic [STATE_W-1:0] state_q;
  logic               mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      mode_q  <= 1'b0;
    end else if (upd_i) begin
      state_q <= {new_mvl_i, new_vl_i};
      mode_q  <= vf_i;
    end
  end

  assign mvl_o  = state_q[STATE_W-1:VL_W];
  assign vl_o   = state_q[VL_W-1:0];
  assign mode_o = mode_q;
endmodule

// File: rtl/vls_unit.sv
`timescale 1ns/1ps
module vls_unit
  import vls_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter logic [5:0]  OPCODE = 6'd22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   ra_val_i,
  output logic              rt_we_o,
  output logic [4:0]        rt_idx_o,
  output logic [XLEN-1:0]   rt_data_o,
  output logic              cr_we_o,
  output logic              zero_o,
  output logic              step_next_o,
  output logic [VL_W-1:0]   mvl_o,
  output logic [VL_W-1:0]   vl_o,
  output logic              vert_mode_o
);
  vls_act_e        act;
  logic [4:0]      rt;
  logic            ra_nz;
  logic [VL_W-1:0] svi;
  logic            vf, vs, ms, rc;
  logic [VL_W-1:0] new_mvl, new_vl;
  logic            upd;
  logic            unused_ra_hi;

  assign unused_ra_hi = ^ra_val_i[XLEN-1:VL_W];

  vls_decode #(.OPCODE(OPCODE)) i_decode (
    .exec_i  (exec_i),
    .insn_i  (insn_i),
    .act_o   (act),
    .rt_o    (rt),
    .ra_nz_o (ra_nz),
    .svi_o   (svi),
    .vf_o    (vf),
    .vs_o    (vs),
    .ms_o    (ms),
    .rc_o    (rc)
  );

  vls_len_select #(.VL_W(VL_W)) i_len_select (
    .svi_i     (svi),
    .ra_nz_i   (ra_nz),
    .ra_low_i  (ra_val_i[VL_W-1:0]),
    .vs_i      (vs),
    .ms_i      (ms),
    .cur_mvl_i (mvl_o),
    .cur_vl_i  (vl_o),
    .new_mvl_o (new_mvl),
    .new_vl_o  (new_vl)
  );

  assign upd = (act == ACT_SET);

  vls_state #(.VL_W(VL_W)) i_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd),
    .new_mvl_i (new_mvl),
    .new_vl_i  (new_vl),
    .vf_i      (vf),
    .mvl_o     (mvl_o),
    .vl_o      (vl_o),
    .mode_o    (vert_mode_o)
  );

  assign step_next_o = (act == ACT_STEP);
  assign rt_we_o     = upd;
  assign rt_idx_o    = rt;
  assign rt_data_o   = upd ? {{(XLEN-VL_W){1'b0}}, new_vl} : '0;
  assign cr_we_o     = upd && rc;
  assign zero_o      = cr_we_o && (new_vl == '0);
endmodule

// File: rtl/vls_unit_chk.sv
`timescale 1ns/1ps
module vls_unit_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VL_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exec_i,
  input logic            vf_i,
  input logic            rt_we_o,
  input logic [XLEN-1:0] rt_data_o,
  input logic            cr_we_o,
  input logic            zero_o,
  input logic            step_next_o,
  input logic [VL_W-1:0] mvl_o,
  input logic [VL_W-1:0] vl_o,
  input logic            vert_mode_o
);
  assert_step_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_next_o |-> (!rt_we_o && !cr_we_o));

  assert_step_keeps_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_next_o |=> ($stable(vl_o) && $stable(mvl_o) && $stable(vert_mode_o)));

  assert_idle_keeps_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> ($stable(vl_o) && $stable(mvl_o) && $stable(vert_mode_o)));

  assert_result_stored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_we_o |=> (vl_o == $past(rt_data_o[VL_W-1:0])));

  assert_result_zero_ext_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_we_o |-> (rt_data_o[XLEN-1:VL_W] == '0));

  assert_vl_within_mvl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_o <= mvl_o);

  assert_mode_written_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_we_o |=> (vert_mode_o == $past(vf_i)));

  assert_zero_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> (zero_o == (rt_data_o == '0)));

  assert_zero_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cr_we_o |-> !zero_o);
endmodule

bind vls_unit vls_unit_chk #(.XLEN(XLEN), .VL_W(vls_pkg::VL_W)) i_vls_unit_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exec_i      (exec_i),
  .vf_i        (insn_i[8]),
  .rt_we_o     (rt_we_o),
  .rt_data_o   (rt_data_o),
  .cr_we_o     (cr_we_o),
  .zero_o      (zero_o),
  .step_next_o (step_next_o),
  .mvl_o       (mvl_o),
  .vl_o        (vl_o),
  .vert_mode_o (vert_mode_o)
);

// File: tb/test_vls_unit.sv
`timescale 1ns/1ps
module test_vls_unit;
  localparam logic [5:0] OPC = 6'd22;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exec_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] ra_val_i = '0;
  logic        rt_we_o, cr_we_o, zero_o, step_next_o, vert_mode_o;
  logic [4:0]  rt_idx_o;
  logic [63:0] rt_data_o;
  logic [6:0]  mvl_o, vl_o;

  int n_checks = 0;
  int n_errors = 0;

  logic        c_we, c_cr, c_zero, c_step;
  logic [4:0]  c_idx;
  logic [63:0] c_data;

  always #5 clk_i = ~clk_i;

  vls_unit i_vls_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .insn_i(insn_i),
    .ra_val_i(ra_val_i), .rt_we_o(rt_we_o), .rt_idx_o(rt_idx_o),
    .rt_data_o(rt_data_o), .cr_we_o(cr_we_o), .zero_o(zero_o),
    .step_next_o(step_next_o), .mvl_o(mvl_o), .vl_o(vl_o),
    .vert_mode_o(vert_mode_o)
  );

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rt,
                                     input logic [4:0] ra, input logic [6:0] svi,
                                     input logic vf, input logic vs, input logic ms,
                                     input logic [4:0] xo, input logic rc);
    return {opc, rt, ra, svi, vf, vs, ms, xo, rc};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at falling edge, capture mid-phase, release after the rising edge
  task automatic run_op(input logic [31:0] w, input logic [63:0] ra, input logic ex);
    @(negedge clk_i);
    insn_i = w; ra_val_i = ra; exec_i = ex;
    #2;
    c_we = rt_we_o; c_idx = rt_idx_o; c_data = rt_data_o;
    c_cr = cr_we_o; c_zero = zero_o; c_step = step_next_o;
    @(negedge clk_i);
    exec_i = 1'b0; insn_i = '0; ra_val_i = '0;
  endtask

  task automatic chk_state(input string req, input logic [6:0] mvl, input logic [6:0] vl,
                           input logic mode);
    chk({req, " mvl"}, 64'(mvl_o), 64'(mvl));
    chk({req, " vl"}, 64'(vl_o), 64'(vl));
    chk({req, " mode"}, 64'(vert_mode_o), 64'(mode));
  endtask

  task automatic t_reset;
    chk_state("R12 reset", 7'd0, 7'd0, 1'b0);
    chk("R12 reset we", 64'(rt_we_o), 64'd0);
    chk("R12 reset step", 64'(step_next_o), 64'd0);
  endtask

  task automatic t_imm_both;
    run_op(mk(OPC, 5'd1, 5'd0, 7'd9, 1'b0, 1'b1, 1'b1, 5'd0, 1'b0), 64'hDEAD, 1'b1);
    chk("R9 we", 64'(c_we), 64'd1);
    chk("R9 idx", 64'(c_idx), 64'd1);
    chk("R5 R3 data", c_data, 64'd10);
    chk("R11 no cr", 64'(c_cr), 64'd0);
    chk_state("R7 R5", 7'd10, 7'd10, 1'b0);
  endtask

  task automatic t_vl_from_reg;
    run_op(mk(OPC, 5'd2, 5'd3, 7'd50, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0),
           64'hFFFF_FFFF_FFFF_FF85, 1'b1);
    chk("R4 data", c_data, 64'd5);
    chk("R9 idx", 64'(c_idx), 64'd2);
    chk_state("R4 R7 keep", 7'd10, 7'd5, 1'b0);
  endtask

  task automatic t_clamp;
    run_op(mk(OPC, 5'd4, 5'd4, 7'd0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0), 64'd100, 1'b1);
    chk("R8 clamp data", c_data, 64'd10);
    chk_state("R8 clamp", 7'd10, 7'd10, 1'b0);
  endtask

  task automatic t_vl_keep;
    run_op(mk(OPC, 5'd5, 5'd0, 7'd3, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0), 64'd0, 1'b1);
    chk("R8 shrink data", c_data, 64'd4);
    chk_state("R6 R8 shrink", 7'd4, 7'd4, 1'b0);
    run_op(mk(OPC, 5'd5, 5'd7, 7'd29, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0), 64'd90, 1'b1);
    chk("R6 keep data", c_data, 64'd4);
    chk_state("R6 keep", 7'd30, 7'd4, 1'b0);
  endtask

  task automatic t_step;
    run_op(mk(OPC, 5'd6, 5'd1, 7'd77, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1), 64'd3, 1'b1);
    chk("R2 step", 64'(c_step), 64'd1);
    chk("R2 no we", 64'(c_we), 64'd0);
    chk("R2 no cr", 64'(c_cr), 64'd0);
    chk_state("R2 held", 7'd30, 7'd4, 1'b0);
  endtask

  task automatic t_vertical;
    run_op(mk(OPC, 5'd8, 5'd0, 7'd20, 1'b1, 1'b1, 1'b1, 5'd0, 1'b0), 64'd0, 1'b1);
    chk("R10 not step", 64'(c_step), 64'd0);
    chk_state("R10 set", 7'd21, 7'd21, 1'b1);
    run_op(mk(OPC, 5'd8, 5'd0, 7'd1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0), 64'd0, 1'b1);
    chk("R2 step mode1", 64'(c_step), 64'd1);
    chk_state("R2 mode held", 7'd21, 7'd21, 1'b1);
    run_op(mk(OPC, 5'd9, 5'd0, 7'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0), 64'd0, 1'b1);
    chk("R6 all keep data", c_data, 64'd21);
    chk("R2 no step", 64'(c_step), 64'd0);
    chk_state("R10 clear", 7'd21, 7'd21, 1'b0);
  endtask

  task automatic t_wrap_zero;
    run_op(mk(OPC, 5'd10, 5'd0, 7'd127, 1'b0, 1'b1, 1'b1, 5'd0, 1'b1), 64'd0, 1'b1);
    chk("R3 wrap data", c_data, 64'd0);
    chk("R11 cr", 64'(c_cr), 64'd1);
    chk("R11 zero", 64'(c_zero), 64'd1);
    chk_state("R3 wrap", 7'd0, 7'd0, 1'b0);
    run_op(mk(OPC, 5'd10, 5'd0, 7'd5, 1'b0, 1'b1, 1'b1, 5'd0, 1'b1), 64'd0, 1'b1);
    chk("R11 cr nz", 64'(c_cr), 64'd1);
    chk("R11 nonzero", 64'(c_zero), 64'd0);
    run_op(mk(OPC, 5'd10, 5'd0, 7'd127, 1'b0, 1'b1, 1'b1, 5'd0, 1'b0), 64'd0, 1'b1);
    chk("R11 rc0 cr", 64'(c_cr), 64'd0);
    chk("R11 rc0 zero", 64'(c_zero), 64'd0);
    run_op(mk(OPC, 5'd10, 5'd0, 7'd5, 1'b0, 1'b1, 1'b1, 5'd0, 1'b0), 64'd0, 1'b1);
    chk_state("R3 six", 7'd6, 7'd6, 1'b0);
  endtask

  task automatic t_ignore;
    run_op(mk(OPC ^ 6'd1, 5'd1, 5'd0, 7'd40, 1'b1, 1'b1, 1'b1, 5'd0, 1'b1), 64'd0, 1'b1);
    chk("R1 bad opc we", 64'(c_we), 64'd0);
    chk("R1 bad opc cr", 64'(c_cr), 64'd0);
    chk_state("R1 bad opc", 7'd6, 7'd6, 1'b0);
    run_op(mk(OPC, 5'd1, 5'd0, 7'd40, 1'b1, 1'b1, 1'b1, 5'd1, 1'b0), 64'd0, 1'b1);
    chk("R1 bad xo we", 64'(c_we), 64'd0);
    chk_state("R1 bad xo", 7'd6, 7'd6, 1'b0);
    run_op(mk(OPC, 5'd1, 5'd0, 7'd40, 1'b1, 1'b1, 1'b1, 5'd0, 1'b0), 64'd0, 1'b0);
    chk("R1 no exec we", 64'(c_we), 64'd0);
    chk_state("R1 no exec", 7'd6, 7'd6, 1'b0);
    run_op(mk(OPC, 5'd1, 5'd0, 7'd0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0), 64'd0, 1'b0);
    chk("R1 no exec step", 64'(c_step), 64'd0);
    run_op(mk(OPC ^ 6'd4, 5'd1, 5'd0, 7'd0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0), 64'd0, 1'b1);
    chk("R1 bad opc step", 64'(c_step), 64'd0);
  endtask

  task automatic t_reset_mid;
    run_op(mk(OPC, 5'd1, 5'd0, 7'd7, 1'b1, 1'b1, 1'b1, 5'd0, 1'b0), 64'd0, 1'b1);
    chk_state("R10 pre reset", 7'd8, 7'd8, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    chk_state("R12 async", 7'd0, 7'd0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  bit done = 1'b0;

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_imm_both();
    t_vl_from_reg();
    t_clamp();
    t_vl_keep();
    t_step();
    t_vertical();
    t_wrap_zero();
    t_ignore();
    t_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule